// File: doc/BRIEF.md
# Buffered Serial Transmitter with Break Frames

This block drives an asynchronous serial line. Software hands it characters through a two-address register port. A one-entry holding buffer sits in front of the shift register. While a frame is on the line, the next character can wait in the buffer, so characters can go out back to back without a gap of a whole bit period.

Bit timing comes from an external oversampling tick. Each bit period lasts sixteen ticks. The block supports 8-bit and 9-bit words and four stop-length codes. Two kinds of special frame are sent: an all-high idle frame whenever the transmitter is enabled, and an all-low break frame on request. Two flags report progress, each with its own interrupt enable:

- buffer empty: the holding buffer can take a new character;
- line done: the last frame has finished and nothing else is waiting.

Top module: `sertx_top`

## Requirements
- R1: After reset, `tx_out` is 1, the status word reads 0x03, and `irq` equals `ie_empty | ie_done`. In the status word, bit 0 is the empty flag, bit 1 is the done flag, and all other bits are 0. `reg_sel`=0 addresses status and `reg_sel`=1 addresses data. `reg_rdata` reads 0 whenever `reg_sel`=1.
- R2: A data frame begins with one low start bit. The data bits follow, least significant first. Every bit lasts 16 `os_tick` pulses. With `cfg_wide`=0 a frame carries 8 data bits.
- R3: With `cfg_wide`=1 a frame carries 9 data bits. The ninth bit is the value `cfg_bit9` had when the character was written.
- R4: Stop bits are driven high after the body. The length comes from `cfg_stop` latched when the frame starts: 00 or 01 gives 16 ticks, 10 gives 32 ticks and 11 gives 24 ticks. The frame ends on the last stop tick.
- R5: When `cfg_en` goes from 0 to 1, any frame in progress is dropped. An idle frame starts on the next clock edge. It is high for 9 bit periods (10 if `cfg_wide`=1) plus the stop ticks, and it goes out before any data or break frame.
- R6: A `brk_req` pulse queues a break frame. The break is low for 10 bit periods (11 if `cfg_wide`=1), or for 13 bit periods when `cfg_lin`=1, and is then followed by the stop ticks. A queued break starts before any buffered character.
- R7: A data write made while the line is busy, while disabled, or while a break is queued stores the character in the holding buffer and clears the empty flag. The buffer starts its frame one cycle after the line frees, and the empty flag is set again at that point.
- R8: A data write made while enabled, idle, with the buffer empty and no break queued starts that character's frame on the next edge. The empty flag stays 1.
- R9: The done flag is set when a frame ends while the empty flag is 1 and no break is queued. Otherwise it keeps its value.
- R10: The done flag is cleared in two ways: by a data write that follows a status read (with no data write between them), or by a status write with bit 1 equal to 0. A data write with no status read before it, or a status write with bit 1 equal to 1, leaves the flag unchanged. Setting wins over clearing in the same cycle.
- R11: `irq` = (empty flag AND `ie_empty`) OR (done flag AND `ie_done`).
- R12: While `cfg_en`=0, ticks are ignored, `tx_out` holds its level and no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling tick, 16 per bit period |
| cfg_en | input | 1 | Transmitter enable |
| cfg_wide | input | 1 | 1 selects 9-bit words |
| cfg_bit9 | input | 1 | Ninth data bit, captured with each data write |
| cfg_stop | input | 2 | Stop length code |
| cfg_lin | input | 1 | Selects 13-bit breaks |
| brk_req | input | 1 | Pulse that queues one break frame |
| ie_empty | input | 1 | Interrupt enable for the empty flag |
| ie_done | input | 1 | Interrupt enable for the done flag |
| reg_sel | input | 1 | 0 status, 1 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| tx_out | output | 1 | Serial line |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases:

- A second character written mid-frame. A design that loaded it straight into the shift register would corrupt the frame on the line.
- The read-then-write sequence that clears the done flag. A wrong design would either clear the flag on any data write or never clear it.
- Breaks in all three lengths, queued behind a busy frame and ahead of a buffered character. An ordering error would show the buffered data before the low run.
- Disabling mid-frame, and writing while disabled. A design that kept counting would move the line. One that skipped the idle frame on re-enable would start data too early.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        FRM_DATA  = 2'd0,
        FRM_BREAK = 2'd1,
        FRM_IDLE  = 2'd2
    } frm_kind_e;

    typedef enum logic {
        PH_BODY = 1'b0,
        PH_STOP = 1'b1
    } phase_e;

    // stop length in oversampling ticks for a stop-code
    function automatic int unsigned stop_ticks(input logic [1:0] code, input int unsigned rate);
        case (code)
            2'b10:   return 2 * rate;
            2'b11:   return rate + rate / 2;
            default: return rate;
        endcase
    endfunction

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              brk_req,
    input  logic              bit9,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              ie_empty,
    input  logic              ie_done,
    input  logic              busy,
    input  logic              frame_end,
    output logic              en_rise,
    output logic              launch,
    output frm_kind_e         launch_kind,
    output logic [DATA_W:0]   launch_data,
    output logic              txe,
    output logic              tc,
    output logic              irq
);

    typedef struct packed {
        logic            en;
        logic            txe;
        logic            tc;
        logic            armed;
        logic            brk;
        logic [DATA_W:0] hold;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    logic can_launch, dwr, swr, srd, direct, start_brk, start_buf, tc_set, tc_clr;

    always_comb begin
        nxt_d      = cur_q;
        en_rise    = en && !cur_q.en;
        can_launch = !busy && en && cur_q.en;
        dwr        = reg_wr && reg_sel;
        swr        = reg_wr && !reg_sel;
        srd        = reg_rd && !reg_sel;
        direct     = dwr && can_launch && !cur_q.brk && cur_q.txe;
        start_brk  = can_launch && cur_q.brk;
        start_buf  = can_launch && !cur_q.brk && !cur_q.txe;

        launch      = direct || start_brk || start_buf;
        launch_kind = start_brk ? FRM_BREAK : FRM_DATA;
        launch_data = direct ? {bit9, reg_wdata} : cur_q.hold;

        nxt_d.en = en;

        if (brk_req)        nxt_d.brk = 1'b1;
        else if (start_brk) nxt_d.brk = 1'b0;

        if (dwr && !direct) begin
            nxt_d.hold = {bit9, reg_wdata};
            nxt_d.txe  = 1'b0;
        end else if (start_buf) begin
            nxt_d.txe  = 1'b1;
        end

        if (srd)      nxt_d.armed = 1'b1;
        else if (dwr) nxt_d.armed = 1'b0;

        tc_set = frame_end && cur_q.txe && !cur_q.brk;
        tc_clr = (dwr && cur_q.armed) || (swr && !reg_wdata[1]);
        if (tc_set)      nxt_d.tc = 1'b1;
        else if (tc_clr) nxt_d.tc = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{en: 1'b0, txe: 1'b1, tc: 1'b1, armed: 1'b0, brk: 1'b0, hold: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign txe = cur_q.txe;
    assign tc  = cur_q.tc;
    assign irq = (cur_q.txe && ie_empty) || (cur_q.tc && ie_done);

    // a write that lands while the line is busy must occupy the buffer
    assert_busy_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && busy) |=> !txe);

    assert_direct_keeps_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && !busy && en && cur_q.en && !cur_q.brk && cur_q.txe) |=> (txe && busy));

    assert_done_on_last_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && txe && !cur_q.brk) |=> tc);

    assert_status_write_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && !reg_wdata[1] && !frame_end) |=> !tc);

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
#(
    parameter int OS_RATE  = 16,
    parameter int DATA_W   = 8,
    parameter int LIN_BITS = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            os_tick,
    input  logic            en,
    input  logic            en_rise,
    input  logic            cfg_wide,
    input  logic            cfg_lin,
    input  logic [1:0]      cfg_stop,
    input  logic            launch,
    input  frm_kind_e       launch_kind,
    input  logic [DATA_W:0] launch_data,
    output logic            busy,
    output logic            frame_end,
    output logic            tx_out
);

    localparam int SUB_W    = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
    localparam int N_BODY   = DATA_W + 1;
    localparam int W_BODY   = DATA_W + 2;
    localparam int N_BRK    = DATA_W + 2;
    localparam int W_BRK    = DATA_W + 3;
    localparam int SH_W     = (LIN_BITS > W_BODY) ? LIN_BITS : W_BODY + 1;
    localparam int CNT_W    = $clog2(SH_W + 1);
    localparam int STOP_W   = $clog2(2 * OS_RATE + 1);

    typedef struct packed {
        logic              busy;
        phase_e            phase;
        logic [SH_W-1:0]   sh;
        logic [CNT_W-1:0]  left;
        logic [SUB_W-1:0]  sub;
        logic [STOP_W-1:0] stop_left;
        logic [1:0]        stop_code;
    } frm_t;

    frm_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        frame_end = 1'b0;
        if (en_rise) begin
            nxt_d.busy      = 1'b1;
            nxt_d.phase     = PH_BODY;
            nxt_d.sub       = '0;
            nxt_d.stop_code = cfg_stop;
            nxt_d.sh        = '1;
            nxt_d.left      = cfg_wide ? CNT_W'(W_BODY) : CNT_W'(N_BODY);
        end else if (en) begin
            if (launch) begin
                nxt_d.busy      = 1'b1;
                nxt_d.phase     = PH_BODY;
                nxt_d.sub       = '0;
                nxt_d.stop_code = cfg_stop;
                if (launch_kind == FRM_BREAK) begin
                    nxt_d.sh   = '0;
                    nxt_d.left = cfg_lin ? CNT_W'(LIN_BITS) : (cfg_wide ? CNT_W'(W_BRK) : CNT_W'(N_BRK));
                end else if (cfg_wide) begin
                    nxt_d.sh   = {{(SH_W-W_BODY){1'b1}}, launch_data, 1'b0};
                    nxt_d.left = CNT_W'(W_BODY);
                end else begin
                    nxt_d.sh   = {{(SH_W-N_BODY){1'b1}}, launch_data[DATA_W-1:0], 1'b0};
                    nxt_d.left = CNT_W'(N_BODY);
                end
            end else if (cur_q.busy && os_tick) begin
                if (cur_q.phase == PH_BODY) begin
                    if (cur_q.sub == SUB_W'(OS_RATE - 1)) begin
                        nxt_d.sub = '0;
                        nxt_d.sh  = {1'b1, cur_q.sh[SH_W-1:1]};
                        if (cur_q.left == CNT_W'(1)) begin
                            nxt_d.phase     = PH_STOP;
                            nxt_d.stop_left = STOP_W'(stop_ticks(cur_q.stop_code, OS_RATE));
                        end else begin
                            nxt_d.left = cur_q.left - CNT_W'(1);
                        end
                    end else begin
                        nxt_d.sub = cur_q.sub + SUB_W'(1);
                    end
                end else begin
                    if (cur_q.stop_left == STOP_W'(1)) begin
                        nxt_d.busy = 1'b0;
                        frame_end  = 1'b1;
                    end else begin
                        nxt_d.stop_left = cur_q.stop_left - STOP_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{busy: 1'b0, phase: PH_BODY, sh: '1, left: '0, sub: '0,
                       stop_left: '0, stop_code: 2'b00};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy   = cur_q.busy;
    assign tx_out = (cur_q.busy && cur_q.phase == PH_BODY) ? cur_q.sh[0] : 1'b1;

    assert_start_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && en && !en_rise && launch_kind == FRM_DATA) |=> !tx_out);

    assert_idle_frame_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (busy && tx_out));

    assert_break_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && en && !en_rise && launch_kind == FRM_BREAK) |=> !tx_out);

    assert_frozen_line_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && busy) |=> ($stable(tx_out) && busy));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int OS_RATE  = 16,
    parameter int DATA_W   = 8,
    parameter int LIN_BITS = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              cfg_en,
    input  logic              cfg_wide,
    input  logic              cfg_bit9,
    input  logic [1:0]        cfg_stop,
    input  logic              cfg_lin,
    input  logic              brk_req,
    input  logic              ie_empty,
    input  logic              ie_done,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tx_out,
    output logic              irq
);

    logic            en_rise, launch, busy, frame_end, txe, tc;
    frm_kind_e       launch_kind;
    logic [DATA_W:0] launch_data;

    sertx_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (cfg_en),
        .brk_req     (brk_req),
        .bit9        (cfg_bit9),
        .reg_sel     (reg_sel),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_wdata   (reg_wdata),
        .ie_empty    (ie_empty),
        .ie_done     (ie_done),
        .busy        (busy),
        .frame_end   (frame_end),
        .en_rise     (en_rise),
        .launch      (launch),
        .launch_kind (launch_kind),
        .launch_data (launch_data),
        .txe         (txe),
        .tc          (tc),
        .irq         (irq)
    );

    sertx_frame #(.OS_RATE(OS_RATE), .DATA_W(DATA_W), .LIN_BITS(LIN_BITS)) frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .os_tick     (os_tick),
        .en          (cfg_en),
        .en_rise     (en_rise),
        .cfg_wide    (cfg_wide),
        .cfg_lin     (cfg_lin),
        .cfg_stop    (cfg_stop),
        .launch      (launch),
        .launch_kind (launch_kind),
        .launch_data (launch_data),
        .busy        (busy),
        .frame_end   (frame_end),
        .tx_out      (tx_out)
    );

    always_comb begin
        reg_rdata = '0;
        if (!reg_sel) begin
            reg_rdata[0] = txe;
            reg_rdata[1] = tc;
        end
    end

    // R1: status reads expose only the two flags
    assert_status_layout_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_sel) |-> ($countones(reg_rdata[DATA_W-1:2]) == 0));

endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       cfg_en = 1'b0, cfg_wide = 1'b0, cfg_bit9 = 1'b0, cfg_lin = 1'b0;
    logic [1:0] cfg_stop = 2'b00;
    logic       brk_req = 1'b0, ie_empty = 1'b0, ie_done = 1'b0;
    logic       reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tx_out, irq;

    int checks = 0, fails = 0, cycles = 0, tdiv = 0;
    string cur_req = "R1";

    // reference model state
    bit       m_q[$];
    bit       m_busy, m_txe, m_tc, m_arm, m_brk, m_enq;
    bit [8:0] m_buf;

    sertx_top dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .cfg_en(cfg_en), .cfg_wide(cfg_wide),
        .cfg_bit9(cfg_bit9), .cfg_stop(cfg_stop), .cfg_lin(cfg_lin), .brk_req(brk_req),
        .ie_empty(ie_empty), .ie_done(ie_done), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_out(tx_out), .irq(irq)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        tdiv    = (tdiv == 2) ? 0 : tdiv + 1;
        os_tick = (tdiv == 0);
    end

    function automatic int stop_len(input logic [1:0] c);
        if (c == 2'b10) return 32;
        if (c == 2'b11) return 24;
        return 16;
    endfunction

    function automatic void push_frame(input bit [15:0] body, input int nb, input logic [1:0] c);
        for (int i = 0; i < nb; i++)
            for (int k = 0; k < 16; k++) m_q.push_back(body[i]);
        for (int k = 0; k < stop_len(c); k++) m_q.push_back(1'b1);
    endfunction

    function automatic void push_data(input bit [8:0] d);
        push_frame({6'b0, d, 1'b0}, cfg_wide ? 10 : 9, cfg_stop);
    endfunction

    task automatic check(input bit [7:0] act, input bit [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", cur_req, what, cycles, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_q.delete(); m_busy = 0; m_txe = 1; m_tc = 1; m_arm = 0; m_brk = 0; m_enq = 0; m_buf = 0;
        end else begin
            bit rise, canl, dwr, direct, sb, sf, fend, o_txe, o_brk, o_arm;
            rise = cfg_en && !m_enq;
            canl = !m_busy && cfg_en && m_enq;
            dwr  = reg_wr && reg_sel;
            o_txe = m_txe; o_brk = m_brk; o_arm = m_arm;
            direct = dwr && canl && !o_brk && o_txe;
            sb   = canl && o_brk;
            sf   = canl && !o_brk && !o_txe;
            fend = 0;
            if (rise) begin
                m_q.delete(); push_frame(16'hFFFF, cfg_wide ? 10 : 9, cfg_stop); m_busy = 1;
            end else if (cfg_en) begin
                if (direct)    begin push_data({cfg_bit9, reg_wdata}); m_busy = 1; end
                else if (sb)   begin push_frame(16'h0000, cfg_lin ? 13 : (cfg_wide ? 11 : 10), cfg_stop); m_busy = 1; end
                else if (sf)   begin push_data(m_buf); m_busy = 1; end
                else if (m_busy && os_tick) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) begin m_busy = 0; fend = 1; end
                end
            end
            if (brk_req) m_brk = 1; else if (sb) m_brk = 0;
            if (dwr && !direct) begin m_buf = {cfg_bit9, reg_wdata}; m_txe = 0; end
            else if (sf) m_txe = 1;
            if (reg_rd && !reg_sel) m_arm = 1; else if (dwr) m_arm = 0;
            if (fend && o_txe && !o_brk) m_tc = 1;
            else if ((dwr && o_arm) || (reg_wr && !reg_sel && !reg_wdata[1])) m_tc = 0;
            m_enq = cfg_en;
        end
        #1;
        check({7'b0, tx_out}, {7'b0, (m_busy && m_q.size() > 0) ? m_q[0] : 1'b1}, "tx_out");
        check({7'b0, irq}, {7'b0, (m_txe && ie_empty) || (m_tc && ie_done)}, "irq R11");
        check(reg_rdata, reg_sel ? 8'h00 : {6'b0, m_tc, m_txe}, "rdata");
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles == 190000) begin
            fails++;
            $display("FAIL watchdog %s: actual=hung expected=done", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr_data(input bit [7:0] d);
        @(negedge clk); reg_sel = 1; reg_wr = 1; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic wr_stat(input bit [7:0] d);
        @(negedge clk); reg_sel = 0; reg_wr = 1; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd_stat();
        @(negedge clk); reg_sel = 0; reg_rd = 1;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic pulse_brk();
        @(negedge clk); brk_req = 1;
        @(negedge clk); brk_req = 0;
    endtask

    task automatic wait_quiet();
        do @(negedge clk); while (m_busy || !m_txe || m_brk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1 reset state with both enables
        ie_empty = 1; ie_done = 1;
        wait_cyc(4);
        rst_n = 1;
        wait_cyc(3);
        ie_empty = 0;

        cur_req = "R5";             // idle frame on enable
        cfg_en = 1;
        wait_quiet();

        cur_req = "R2";             // narrow frame, direct load (R8)
        wr_data(8'hA5);
        wait_quiet();
        cur_req = "R8";
        wr_data(8'h3C);
        wait_quiet();

        cur_req = "R3";             // wide word, ninth bit captured at write
        cfg_wide = 1; cfg_bit9 = 1; cfg_stop = 2'b10;
        wr_data(8'h81);
        cfg_bit9 = 0;
        wait_quiet();

        cur_req = "R4";             // the 1.5-stop and 01 codes
        cfg_wide = 0; cfg_stop = 2'b11;
        wr_data(8'h0F);
        wait_quiet();
        cfg_stop = 2'b01;
        wr_data(8'hF0);
        wait_quiet();
        cfg_stop = 2'b00;

        cur_req = "R7";             // back to back through the buffer
        wr_data(8'h11);
        wait_cyc(20);
        wr_data(8'h22);
        wait_cyc(100);
        wr_data(8'h33);
        wait_quiet();

        cur_req = "R10";            // done flag clearing sequences
        wr_data(8'h44);             // no prior read: done flag remains
        wait_quiet();
        rd_stat();
        wr_data(8'h55);             // read then write clears
        wait_cyc(30);
        wait_quiet();
        wr_stat(8'h02);             // bit1 = 1: no effect
        wait_cyc(2);
        wr_stat(8'h00);             // bit1 = 0: clears
        wait_cyc(4);

        cur_req = "R9";             // done only after the last frame
        rd_stat();
        wr_data(8'h66);
        wait_cyc(10);
        wr_data(8'h77);
        wait_quiet();

        cur_req = "R6";             // break lengths and ordering
        pulse_brk();
        wait_quiet();
        cfg_wide = 1;
        wr_data(8'h99);
        wait_cyc(10);
        pulse_brk();
        wr_data(8'hAA);             // buffered behind the break
        wait_quiet();
        cfg_lin = 1; cfg_wide = 0;
        pulse_brk();
        wait_quiet();
        cfg_lin = 0;

        cur_req = "R11";
        ie_empty = 1; ie_done = 0;
        wr_data(8'h12);
        wait_cyc(5);
        wr_data(8'h34);
        ie_done = 1;
        wait_quiet();
        ie_empty = 0;

        cur_req = "R12";            // freeze mid frame, write while disabled
        wr_data(8'hC3);
        wait_cyc(90);
        cfg_en = 0;
        wait_cyc(120);
        wr_data(8'h5A);
        wait_cyc(40);
        cur_req = "R5";
        cfg_en = 1;                 // drops the frame, idle first, then buffer
        wait_quiet();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule